// File: doc/BRIEF.md
# Writeback frame capture controller

This block sequences the capture of one video frame into memory. Software sets a destination start address, a byte stride between lines, and a packed line count and line length. It then writes a control word whose launch bit starts the frame. The block accepts lines from an upstream compositor stream, one line per beat. For each line it issues a single write request on a plain valid/ready port, at the address of that line.

While a frame runs, the block reports itself busy and counts the lines that memory has accepted. Software can cut a frame short with an abort bit. The block can send a fresh frame-start pulse upstream when a frame completes. It holds a level interrupt while it is idle and the interrupt is enabled; software acknowledges by clearing the enable. A power-down bit keeps any frame from starting.

Top module: `wbc_capture`

## Requirements
- R1: After reset, the control word at offset 0x0C reads 0x5440_0000, with bits 31:24 = 0x54 and bits 23:22 = 2'b01 as fixed identity fields and every other bit 0. The progress word reads 0, and every output is low.
- R2: The start address is at offset 0x00 and always reads back with bits 1:0 zero. The stride is at offset 0x04 and reads back with bits 3:0 zero. The size word is at 0x08, with the line count in bits 31:16 and the line length in bits 15:0. Progress is at 0x10. Writes to 0x00, 0x04 and 0x08 are ignored while busy.
- R3: A control write with bit 0 set launches a frame when all of these hold: the block is idle, the line count is nonzero, and bits 14 and 21 of the same word are clear. On the next cycle busy (control bit 1) reads 1, progress reads 0 and vstart_o is high for exactly one cycle. Bit 0 always reads 0.
- R4: Line n (counting from 0) is written at start address + n * stride, with the line's data. line_ready_o is high only while busy with no write outstanding.
- R5: A write request keeps wr_valid_o high and wr_addr_o and wr_data_o unchanged until wr_ready_i accepts it.
- R6: Each accepted write adds one to progress. Busy clears in the cycle after the write for the last line is accepted.
- R7: When control bit 15 is set, vstart_o pulses for one cycle after the last write of a frame is accepted. When bit 15 is clear, it stays low at that point.
- R8: irq_o is high exactly when control bit 2 is set and the block is idle. Writing bit 2 as 0 drops irq_o.
- R9: A control write with bit 14 set clears busy on the next cycle and drops any outstanding write request. After that no line is accepted and no write is issued, and progress keeps its value.
- R10: Control bit 21 reads back as written. A launch word that has bit 21 set starts no frame.
- R11: A launch request is ignored while busy, and progress is not cleared. A launch request is also ignored when the line count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| line_valid_i | input | 1 | Upstream line present |
| line_data_i | input | LINE_W | Upstream line data |
| line_ready_o | output | 1 | Line accepted when high with line_valid_i |
| vstart_o | output | 1 | Frame-start pulse to upstream |
| wr_valid_o | output | 1 | Write request present |
| wr_addr_o | output | ADDR_W | Write byte address |
| wr_data_o | output | LINE_W | Write data |
| wr_ready_i | input | 1 | Write request accepted |
| irq_o | output | 1 | Idle interrupt |

## Verification
The hardest case to reach is an abort that arrives while a write request is stalled. To get there, the bench stops after a line handshake and holds wr_ready_i low, so a request is outstanding and one line has been accepted but not committed, and then issues the abort write. It then raises wr_ready_i and offers more lines to show that nothing leaks out afterwards. A second case is a launch and an address change that both arrive mid-frame. These are driven between lines of a running frame, and the bench checks that the frame keeps its old addresses and its progress count.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_BASE  = 5'h00;
  localparam logic [REG_AW-1:0] OFS_PITCH = 5'h04;
  localparam logic [REG_AW-1:0] OFS_DIM   = 5'h08;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_PROG  = 5'h10;

  localparam int CB_GO    = 0;
  localparam int CB_BUSY  = 1;
  localparam int CB_EI    = 2;
  localparam int CB_ABORT = 14;
  localparam int CB_VSE   = 15;
  localparam int CB_PD    = 21;

  localparam logic [7:0] ID_MARK = 8'h54;
  localparam logic [1:0] ID_REV  = 2'b01;

  localparam int BASE_ALIGN  = 2;
  localparam int PITCH_ALIGN = 4;

  typedef struct packed {
    logic pd;
    logic vse;
    logic ei;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LINE  = 2'd1,
    ST_WRITE = 2'd2
  } seq_st_e;
endpackage

// File: rtl/wbc_regs.sv
module wbc_regs
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              busy_i,
  input  logic [DIM_W-1:0]  progress_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] pitch_o,
  output logic [DIM_W-1:0]  width_o,
  output logic [DIM_W-1:0]  height_o,
  output ctrl_t             ctrl_o,
  output logic              launch_o,
  output logic              abort_o,
  output logic              irq_o,
  output logic [31:0]       rdata_o
);
  localparam logic [ADDR_W-1:0] BASE_MASK  = ~ADDR_W'((1 << BASE_ALIGN) - 1);
  localparam logic [ADDR_W-1:0] PITCH_MASK = ~ADDR_W'((1 << PITCH_ALIGN) - 1);

  logic wr_base, wr_pitch, wr_dim, wr_ctrl;
  logic [31:0] ctrl_rd;

  assign wr_base  = reg_we_i && (reg_addr_i == OFS_BASE);
  assign wr_pitch = reg_we_i && (reg_addr_i == OFS_PITCH);
  assign wr_dim   = reg_we_i && (reg_addr_i == OFS_DIM);
  assign wr_ctrl  = reg_we_i && (reg_addr_i == OFS_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o   <= '0;
      pitch_o  <= '0;
      width_o  <= '0;
      height_o <= '0;
      ctrl_o   <= '0;
    end else begin
      // frame geometry frozen while a frame runs
      if (wr_base && !busy_i)  base_o  <= reg_wdata_i[ADDR_W-1:0] & BASE_MASK;
      if (wr_pitch && !busy_i) pitch_o <= reg_wdata_i[ADDR_W-1:0] & PITCH_MASK;
      if (wr_dim && !busy_i) begin
        height_o <= reg_wdata_i[16 +: DIM_W];
        width_o  <= reg_wdata_i[0 +: DIM_W];
      end
      if (wr_ctrl) begin
        ctrl_o.ei  <= reg_wdata_i[CB_EI];
        ctrl_o.vse <= reg_wdata_i[CB_VSE];
        ctrl_o.pd  <= reg_wdata_i[CB_PD];
      end
    end
  end

  assign launch_o = wr_ctrl && reg_wdata_i[CB_GO] && !reg_wdata_i[CB_ABORT] &&
                    !reg_wdata_i[CB_PD] && !busy_i && (height_o != '0);
  assign abort_o  = wr_ctrl && reg_wdata_i[CB_ABORT];
  assign irq_o    = ctrl_o.ei && !busy_i;

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[31:24]   = ID_MARK;
    ctrl_rd[23:22]   = ID_REV;
    ctrl_rd[CB_PD]   = ctrl_o.pd;
    ctrl_rd[CB_VSE]  = ctrl_o.vse;
    ctrl_rd[CB_EI]   = ctrl_o.ei;
    ctrl_rd[CB_BUSY] = busy_i;
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_i)
      OFS_BASE:  rdata_o = 32'(base_o);
      OFS_PITCH: rdata_o = 32'(pitch_o);
      OFS_DIM:   begin
        rdata_o[16 +: DIM_W] = height_o;
        rdata_o[0 +: DIM_W]  = width_o;
      end
      OFS_CTRL:  rdata_o = ctrl_rd;
      OFS_PROG:  rdata_o = 32'(progress_i);
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wbc_addr.sv
module wbc_addr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] pitch_i,
  output logic [ADDR_W-1:0] addr_o
);
  // running sum replaces a line-index multiply
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= base_i;
    else if (step_i) addr_o <= addr_o + pitch_i;
  end
endmodule

// File: rtl/wbc_seq.sv
module wbc_seq
  import wbc_pkg::*;
#(
  parameter int DIM_W  = 16,
  parameter int LINE_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              abort_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic              vse_i,
  input  logic              line_valid_i,
  input  logic [LINE_W-1:0] line_data_i,
  output logic              line_ready_o,
  input  logic              wr_ready_i,
  output logic              wr_valid_o,
  output logic [LINE_W-1:0] wr_data_o,
  output logic              step_o,
  output logic              busy_o,
  output logic [DIM_W-1:0]  progress_o,
  output logic              vstart_o
);
  seq_st_e st_q, st_d;
  logic accept, commit, last;

  assign line_ready_o = (st_q == ST_LINE);
  assign wr_valid_o   = (st_q == ST_WRITE);
  assign busy_o       = (st_q != ST_IDLE);
  assign accept       = line_valid_i && line_ready_o;
  assign commit       = wr_valid_o && wr_ready_i && !abort_i;
  assign last         = commit && ((progress_o + DIM_W'(1)) == height_i);
  assign step_o       = commit;

  always_comb begin
    st_d = st_q;
    if (abort_i) st_d = ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE:  if (launch_i) st_d = ST_LINE;
        ST_LINE:  if (accept)   st_d = ST_WRITE;
        ST_WRITE: if (commit)   st_d = last ? ST_IDLE : ST_LINE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      wr_data_o  <= '0;
      progress_o <= '0;
      vstart_o   <= 1'b0;
    end else begin
      st_q     <= st_d;
      vstart_o <= launch_i || (last && vse_i);
      if (launch_i)    progress_o <= '0;
      else if (commit) progress_o <= progress_o + DIM_W'(1);
      if (accept)      wr_data_o  <= line_data_i;
    end
  end
endmodule

// File: rtl/wbc_capture.sv
module wbc_capture
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16,
  parameter int LINE_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [4:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              line_valid_i,
  input  logic [LINE_W-1:0] line_data_i,
  output logic              line_ready_o,
  output logic              vstart_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [LINE_W-1:0] wr_data_o,
  input  logic              wr_ready_i,
  output logic              irq_o
);
  logic [ADDR_W-1:0] cfg_base, cfg_pitch;
  logic [DIM_W-1:0]  cfg_width, cfg_height, progress;
  ctrl_t             ctrl;
  logic              launch, abort, busy, step;

  wbc_regs #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .busy_i     (busy),
    .progress_i (progress),
    .base_o     (cfg_base),
    .pitch_o    (cfg_pitch),
    .width_o    (cfg_width),
    .height_o   (cfg_height),
    .ctrl_o     (ctrl),
    .launch_o   (launch),
    .abort_o    (abort),
    .irq_o      (irq_o),
    .rdata_o    (reg_rdata_o)
  );

  wbc_seq #(.DIM_W(DIM_W), .LINE_W(LINE_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .abort_i     (abort),
    .height_i    (cfg_height),
    .vse_i       (ctrl.vse),
    .line_valid_i(line_valid_i),
    .line_data_i (line_data_i),
    .line_ready_o(line_ready_o),
    .wr_ready_i  (wr_ready_i),
    .wr_valid_o  (wr_valid_o),
    .wr_data_o   (wr_data_o),
    .step_o      (step),
    .busy_o      (busy),
    .progress_o  (progress),
    .vstart_o    (vstart_o)
  );

  wbc_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (launch),
    .step_i (step),
    .base_i (cfg_base),
    .pitch_i(cfg_pitch),
    .addr_o (wr_addr_o)
  );
endmodule

// File: rtl/wbc_capture_chk.sv
module wbc_capture_chk #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16,
  parameter int LINE_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_wr_i,
  input logic              go_bit_i,
  input logic              abort_bit_i,
  input logic              pd_bit_i,
  input logic              busy_i,
  input logic [DIM_W-1:0]  height_i,
  input logic              line_ready_i,
  input logic              wr_valid_i,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [LINE_W-1:0] wr_data_i,
  input logic              vstart_i,
  input logic              irq_i
);
  logic launch_req;
  assign launch_req = ctrl_wr_i && go_bit_i && !abort_bit_i && !pd_bit_i &&
                      !busy_i && (height_i != '0);

  AST_LAUNCH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_req |=> busy_i); // R3
  AST_LAUNCH_VSTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_req |=> vstart_i); // R3
  AST_READY_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !line_ready_i); // R4
  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !wr_ready_i && !(ctrl_wr_i && abort_bit_i)) |=>
    (wr_valid_i && $stable(wr_addr_i) && $stable(wr_data_i))); // R5
  AST_VSTART_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vstart_i |=> !vstart_i); // R7
  AST_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> !busy_i); // R8
  AST_ABORT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && abort_bit_i) |=> (!busy_i && !wr_valid_i)); // R9
  AST_PD_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && pd_bit_i && !busy_i) |=> !busy_i); // R10
endmodule

bind wbc_capture wbc_capture_chk #(
  .ADDR_W(ADDR_W), .DIM_W(DIM_W), .LINE_W(LINE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_wr_i   (reg_we_i && (reg_addr_i == 5'h0C)),
  .go_bit_i    (reg_wdata_i[0]),
  .abort_bit_i (reg_wdata_i[14]),
  .pd_bit_i    (reg_wdata_i[21]),
  .busy_i      (busy),
  .height_i    (cfg_height),
  .line_ready_i(line_ready_o),
  .wr_valid_i  (wr_valid_o),
  .wr_ready_i  (wr_ready_i),
  .wr_addr_i   (wr_addr_o),
  .wr_data_i   (wr_data_o),
  .vstart_i    (vstart_o),
  .irq_i       (irq_o)
);

// File: tb/sim_wbc_capture.sv
`timescale 1ns/1ps
module sim_wbc_capture;
  localparam int AW = 32;
  localparam int LW = 64;
  localparam logic [4:0] A_BASE = 5'h00, A_PITCH = 5'h04, A_DIM = 5'h08,
                         A_CTRL = 5'h0C, A_PROG = 5'h10;
  localparam logic [31:0] GO = 32'h1, EI = 32'h4, ABT = 32'h4000,
                          VSE = 32'h8000, PD = 32'h20_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic line_valid = 1'b0;
  logic [LW-1:0] line_data = '0;
  logic line_ready, vstart, wr_valid, wr_ready = 1'b0, irq;
  logic [AW-1:0] wr_addr;
  logic [LW-1:0] wr_data;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wbc_capture u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .line_valid_i(line_valid),
    .line_data_i(line_data), .line_ready_o(line_ready), .vstart_o(vstart),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_ready_i(wr_ready), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  // one line: handshake, optional stall, accept write
  task automatic do_line(input int n, input logic [AW-1:0] exp_addr,
                         input logic [LW-1:0] d, input int stall);
    logic [31:0] v;
    line_valid = 1'b1; line_data = d;
    while (!line_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    line_valid = 1'b0;
    chk(wr_valid, "R4 wr_valid", 64'(wr_valid), 1);
    chk(wr_addr == exp_addr, "R4 line addr", 64'(wr_addr), 64'(exp_addr));
    chk(wr_data == d, "R4 line data", wr_data, d);
    chk(!line_ready, "R4 ready while pending", 64'(line_ready), 0);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(wr_valid && wr_addr == exp_addr && wr_data == d, "R5 hold",
          64'(wr_addr), 64'(exp_addr));
    end
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
    rd_reg(A_PROG, v);
    chk(v == 32'(n + 1), "R6 progress", 64'(v), 64'(n + 1));
  endtask

  task automatic run_frame(input logic [AW-1:0] base, input logic [31:0] pitch,
                           input int h, input bit vse, input bit ei, input int stall);
    logic [31:0] v;
    wr_reg(A_BASE, base);
    wr_reg(A_PITCH, pitch);
    wr_reg(A_DIM, {16'(h), 16'd8});
    wr_reg(A_CTRL, GO | (ei ? EI : 0) | (vse ? VSE : 0));
    chk(vstart, "R3 vstart on launch", 64'(vstart), 1);
    rd_reg(A_CTRL, v);
    chk(v[1] && !v[0], "R3 busy set, go clear", 64'(v[1:0]), 2);
    rd_reg(A_PROG, v);
    chk(v == 0, "R3 progress cleared", 64'(v), 0);
    @(negedge clk);
    chk(!vstart, "R3 vstart one cycle", 64'(vstart), 0);
    for (int n = 0; n < h; n++) begin
      if (n == h - 1)
        chk(!vstart, "R7 no early vstart", 64'(vstart), 0);
      do_line(n, base + AW'(n) * pitch, {base, 32'(n * 7 + 1)}, stall);
      if (n == h - 1) begin
        chk(vstart == vse, "R7 vstart at end", 64'(vstart), 64'(vse));
        rd_reg(A_CTRL, v);
        chk(!v[1], "R6 busy clears", 64'(v[1]), 0);
        chk(irq == ei, "R8 irq at idle", 64'(irq), 64'(ei));
      end
    end
    if (ei) begin
      wr_reg(A_CTRL, 32'h0);
      chk(!irq, "R8 irq ack", 64'(irq), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pitches [3] = '{32'h10, 32'h30, 32'h100};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(A_CTRL, v);
    chk(v == 32'h5440_0000, "R1 ctrl reset", 64'(v), 64'h5440_0000);
    rd_reg(A_PROG, v);
    chk(v == 0, "R1 progress reset", 64'(v), 0);
    chk(!line_ready && !wr_valid && !vstart && !irq, "R1 outputs idle",
        {60'd0, line_ready, wr_valid, vstart, irq}, 0);

    // R2 alignment and packing
    wr_reg(A_BASE, 32'h0000_1003);
    rd_reg(A_BASE, v);
    chk(v == 32'h1000, "R2 base align", 64'(v), 64'h1000);
    wr_reg(A_PITCH, 32'h47);
    rd_reg(A_PITCH, v);
    chk(v == 32'h40, "R2 pitch align", 64'(v), 64'h40);
    wr_reg(A_DIM, 32'h0003_0123);
    rd_reg(A_DIM, v);
    chk(v == 32'h0003_0123, "R2 dim readback", 64'(v), 64'h0003_0123);

    // R11 zero line count
    wr_reg(A_DIM, 32'h0);
    wr_reg(A_CTRL, GO);
    chk(!vstart, "R11 zero height no vstart", 64'(vstart), 0);
    rd_reg(A_CTRL, v);
    chk(!v[1], "R11 zero height idle", 64'(v[1]), 0);

    // sweep of frames
    for (int h = 1; h <= 4; h++)
      for (int p = 0; p < 3; p++)
        run_frame(32'h1000_0000 + 32'(h) * 32'h1000 + 32'(p) * 32'h40,
                  pitches[p], h, ((h + p) % 2) == 1, (h % 2) == 0, (h + p) % 3);

    // R2/R11 writes while busy
    wr_reg(A_BASE, 32'h2000_0000);
    wr_reg(A_PITCH, 32'h20);
    wr_reg(A_DIM, {16'd3, 16'd8});
    wr_reg(A_CTRL, GO);
    @(negedge clk);
    do_line(0, 32'h2000_0000, 64'hA0, 0);
    wr_reg(A_BASE, 32'h3000_0000);
    rd_reg(A_BASE, v);
    chk(v == 32'h2000_0000, "R2 base frozen", 64'(v), 64'h2000_0000);
    wr_reg(A_CTRL, GO);
    chk(!vstart, "R11 relaunch no vstart", 64'(vstart), 0);
    rd_reg(A_PROG, v);
    chk(v == 1, "R11 progress kept", 64'(v), 1);
    do_line(1, 32'h2000_0020, 64'hA1, 1);
    do_line(2, 32'h2000_0040, 64'hA2, 0);
    rd_reg(A_CTRL, v);
    chk(!v[1], "R6 frame done", 64'(v[1]), 0);

    // R9 abort with write outstanding
    wr_reg(A_BASE, 32'h4000_0000);
    wr_reg(A_PITCH, 32'h40);
    wr_reg(A_DIM, {16'd4, 16'd8});
    wr_reg(A_CTRL, GO | EI);
    @(negedge clk);
    do_line(0, 32'h4000_0000, 64'hB0, 0);
    do_line(1, 32'h4000_0040, 64'hB1, 0);
    line_valid = 1'b1; line_data = 64'hB2;
    @(posedge clk); @(negedge clk);
    line_valid = 1'b0;
    chk(wr_valid, "R9 pending before abort", 64'(wr_valid), 1);
    wr_reg(A_CTRL, ABT | EI);
    chk(!wr_valid, "R9 write dropped", 64'(wr_valid), 0);
    chk(!line_ready, "R9 no ready", 64'(line_ready), 0);
    rd_reg(A_CTRL, v);
    chk(!v[1], "R9 busy cleared", 64'(v[1]), 0);
    rd_reg(A_PROG, v);
    chk(v == 2, "R9 progress held", 64'(v), 2);
    chk(irq, "R8 irq after abort", 64'(irq), 1);
    line_valid = 1'b1; wr_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!wr_valid && !line_ready, "R9 nothing after abort", 64'(wr_valid), 0);
    end
    line_valid = 1'b0; wr_ready = 1'b0;
    wr_reg(A_CTRL, 32'h0);
    chk(!irq, "R8 irq ack", 64'(irq), 0);

    // R10 power-down
    wr_reg(A_CTRL, PD | GO);
    chk(!vstart, "R10 pd no vstart", 64'(vstart), 0);
    rd_reg(A_CTRL, v);
    chk(v[21] && !v[1], "R10 pd readback, idle", 64'(v[21:20]), 2);
    wr_reg(A_CTRL, GO);
    rd_reg(A_CTRL, v);
    chk(v[1] && !v[21], "R10 launch after pd clear", 64'(v[1]), 1);
    wr_reg(A_CTRL, ABT);
    rd_reg(A_CTRL, v);
    chk(!v[1], "R9 abort idle", 64'(v[1]), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule